// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one active-low external interrupt pin and keeps a pending request in a single latch. Triggering comes in two kinds. By default only a falling edge on the pin sets the latch. With the trigger-select bit set, a falling edge sets it and a low level keeps it pending until the request has been acknowledged and the pin has gone high again.

Software reaches the block through an 8-bit control/status register on a plain write-strobe bus, with a combinational read port. The register shows the pending flag and holds a local mask and the trigger-select bit. It also has a write-only acknowledge bit. The CPU can clear a request either by writing that acknowledge bit or by pulsing a vector-fetch strobe. A single request output goes to the priority logic. Both the local mask and a global interrupt-disable input can hold that output low, and a masked event is still recorded in the latch.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and `irq_req` is 0.
- R2: Register bit 3 shows the pending flag and cannot be written. Bit 1 is the mask and bit 0 the trigger select (1 = edge plus level), and both read back what was written. Bits 7..4 and bit 2 always read 0.
- R3: Writing 1 to bit 2 acknowledges the pending request. Writing 0 there has no effect on the flag.
- R4: The pin passes through a two-flop synchronizer. A falling edge sets the flag on the third rising clock edge after the pin goes low, and not before.
- R5: In edge-only mode the flag stays set while the pin stays low. An acknowledge write or a `vec_fetch` pulse clears it on the next clock edge.
- R6: In edge-plus-level mode, an acknowledge that arrives while the pin is low leaves the flag set. The flag clears on the third clock edge after the pin returns high.
- R7: In edge-plus-level mode, an acknowledge that arrives when the pin is already high clears the flag on the next clock edge. If the pin has gone high without an acknowledge, the flag stays set.
- R8: A new falling edge detected in the same cycle as an acknowledge wins, and the flag stays set.
- R9: While the mask bit is 1, `irq_req` is 0. A falling edge still sets the flag.
- R10: While `global_disable` is 1, `irq_req` is 0.
- R11: Reset clears the flag and the trigger-select bit even when the pin is held low, and no request appears after reset is released while the pin stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| vec_fetch | input | 1 | CPU vector-fetch strobe, acts as an acknowledge |
| global_disable | input | 1 | Global interrupt disable |
| irq_req | output | 1 | Interrupt request toward the priority logic |

## Verification
A pin transition reaches the flag on the third rising edge after it is driven, because it passes two synchronizer flops and then the edge-detect stage. A register write or a vector-fetch pulse takes effect on the first edge, and the request output follows the flag, mask and global disable with no extra cycle. The bench drives every input just after a falling clock edge and counts whole falling edges before it samples. To pin down the synchronizer latency it also checks the flag one cycle early. The collision test places the acknowledge write exactly in the cycle where the synchronized edge is seen.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_pin_n,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          vec_fetch,
  input  logic          global_disable,
  output logic          irq_req
);
  localparam int FLAG_B = 3;
  localparam int ACK_B  = 2;
  localparam int MASK_B = 1;
  localparam int MODE_B = 0;

  logic [2:0] sync_q;
  logic       pin_s, fall;
  logic       mode, mask, flag, acked;
  logic       ack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], irq_pin_n};

  assign pin_s = sync_q[1];
  assign fall  = sync_q[2] & ~sync_q[1];
  assign ack   = (reg_wr & reg_wdata[ACK_B]) | vec_fetch;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= 1'b0;
      mask <= 1'b0;
    end else if (reg_wr) begin
      mode <= reg_wdata[MODE_B];
      mask <= reg_wdata[MASK_B];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag  <= 1'b0;
      acked <= 1'b0;
    end else if (fall) begin
      flag  <= 1'b1;
      acked <= 1'b0;
    end else if (!mode) begin
      if (ack) begin
        flag  <= 1'b0;
        acked <= 1'b0;
      end
    end else if ((ack || acked) && pin_s) begin
      flag  <= 1'b0;
      acked <= 1'b0;
    end else if (ack && flag) begin
      acked <= 1'b1;
    end

  always_comb begin
    reg_rdata         = '0;
    reg_rdata[FLAG_B] = flag;
    reg_rdata[MASK_B] = mask;
    reg_rdata[MODE_B] = mode;
  end

  assign irq_req = flag & ~mask & ~global_disable;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic       global_disable,
  input logic       irq_req,
  input logic       mode,
  input logic       mask,
  input logic       flag,
  input logic       pin_s,
  input logic       fall,
  input logic       ack
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:4] == 4'b0 && reg_rdata[2] == 1'b0);

  a_r5_edge_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && ack && !fall) |=> !flag);

  a_r6_level_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && flag && !pin_s && !reg_wr) |=> flag);

  a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> flag);

  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq_req);

  a_r10_gdis_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    global_disable |-> !irq_req);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
  .global_disable(global_disable), .irq_req(irq_req), .mode(mode),
  .mask(mask), .flag(flag), .pin_s(pin_s), .fall(fall), .ack(ack)
);

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       irq_pin_n = 1;
  logic       reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       vec_fetch = 0;
  logic       global_disable = 0;
  logic       irq_req;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_fetch(vec_fetch),
    .global_disable(global_disable), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    cyc(2); rst_n = 1;
  endtask

  task automatic fall_pin();
    @(negedge clk); irq_pin_n = 0;
    cyc(3);
  endtask

  task automatic rise_pin();
    @(negedge clk); irq_pin_n = 1;
    cyc(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reg", reg_rdata, 8'h00);
    chk("R1 irq", irq_req, 0);
  endtask

  task automatic t_layout();
    wr(8'hFB);
    chk("R2 layout", reg_rdata, 8'h03);
    wr(8'h00);
    chk("R2 cleared", reg_rdata, 8'h00);
  endtask

  task automatic t_edge_sw();
    @(negedge clk); irq_pin_n = 0;
    cyc(2);
    chk("R4 not yet", reg_rdata[3], 0);
    cyc(1);
    chk("R4 flag set", reg_rdata[3], 1);
    chk("R4 irq", irq_req, 1);
    wr(8'h00);
    chk("R3 write0 no effect", reg_rdata[3], 1);
    wr(8'h04);
    chk("R5 sw clear", reg_rdata[3], 0);
    chk("R3 ack reads 0", reg_rdata, 8'h00);
    cyc(4);
    chk("R5 low pin no retrigger", reg_rdata[3], 0);
    rise_pin();
  endtask

  task automatic t_vec();
    fall_pin();
    cyc(3);
    chk("R5 held while low", reg_rdata[3], 1);
    @(negedge clk); vec_fetch = 1;
    @(negedge clk); vec_fetch = 0;
    chk("R5 vec clear", reg_rdata[3], 0);
    rise_pin();
  endtask

  task automatic t_mask_gdis();
    wr(8'h02);
    fall_pin();
    chk("R9 flag records", reg_rdata[3], 1);
    chk("R9 irq masked", irq_req, 0);
    wr(8'h00);
    chk("R9 unmasked", irq_req, 1);
    @(negedge clk); global_disable = 1;
    #1 chk("R10 gdis", irq_req, 0);
    @(negedge clk); global_disable = 0;
    #1 chk("R10 released", irq_req, 1);
    wr(8'h04);
    rise_pin();
  endtask

  task automatic t_level_ack_first();
    wr(8'h01);
    fall_pin();
    wr(8'h05);
    chk("R6 pending while low", reg_rdata[3], 1);
    cyc(3);
    chk("R6 still pending", reg_rdata[3], 1);
    @(negedge clk); irq_pin_n = 1;
    cyc(2);
    chk("R6 before release seen", reg_rdata[3], 1);
    cyc(1);
    chk("R6 cleared on release", reg_rdata[3], 0);
  endtask

  task automatic t_level_release_first();
    fall_pin();
    rise_pin();
    cyc(2);
    chk("R7 no ack keeps", reg_rdata[3], 1);
    @(negedge clk); vec_fetch = 1;
    @(negedge clk); vec_fetch = 0;
    chk("R7 ack clears", reg_rdata[3], 0);
  endtask

  task automatic t_collision();
    wr(8'h00);
    fall_pin();
    rise_pin();
    @(negedge clk); irq_pin_n = 0;
    cyc(2);
    reg_wr = 1; reg_wdata = 8'h04;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
    chk("R8 edge wins", reg_rdata[3], 1);
    wr(8'h04);
    rise_pin();
  endtask

  task automatic t_reset_level();
    wr(8'h01);
    fall_pin();
    do_reset();
    chk("R11 reg cleared", reg_rdata, 8'h00);
    cyc(5);
    chk("R11 no request", reg_rdata[3], 0);
    chk("R11 irq", irq_req, 0);
    rise_pin();
  endtask

  initial begin
    t_reset();
    t_layout();
    t_edge_sw();
    t_vec();
    t_mask_gdis();
    t_level_ack_first();
    t_level_release_first();
    t_collision();
    t_reset_level();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule